// File: doc/BRIEF.md
# Block Load/Store Address Sequencer

This block carries out a multiple-register memory transfer. A single start pulse delivers a base address, a 16-bit register mask and a set of mode flags. The sequencer then walks the mask and issues one 32-bit word access for each selected register. It has one request in flight at a time. Each access uses a register-file read/write port on one side and a memory request/ready handshake on the other.

The direction flag sets the order in which registers are visited and whether the address rises or falls. The placement flag decides whether the 4-byte step is taken before or after each access. When the transfer finishes, the block pulses a completion flag. At the same time it presents the address reached after the last access, so the caller can write it back into the base register. Two mask and mode combinations are refused as undefined, and nothing touches memory for them.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start with mask bit 15 set, or with `priv_i` high, gives `done_o` and `undef_o` high together in the next cycle. It makes no memory request, no register write and no writeback (`wb_valid_o` low).
- R2: With `up_i` high, registers are visited in ascending index order (mask bit i is register i), and each access address is 4 above the previous one.
- R3: With `up_i` low, registers are visited in descending index order, and each access address is 4 below the previous one.
- R4: With `pre_i` high, the first access goes to base±4 (the step comes before each access). With `pre_i` low, the first access goes to the base itself (the step follows each access).
- R5: With `load_i` high, `rf_we_o` is high exactly in the cycles where a request is accepted (`mem_ready_i` high). `rf_wdata_o` then equals `mem_rdata_i` and `rf_idx_o` names the current register.
- R6: With `load_i` low, the request has `mem_we_o` high and `mem_wdata_o` equal to the register-file read data of the current register.
- R7: At completion, `wb_valid_o` equals the latched writeback flag and `wb_idx_o` holds the latched base register number. `wb_addr_o` equals base + 4·n when ascending, or base − 4·n when descending, for n selected registers.
- R8: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, write flag and register index stay unchanged in the next cycle.
- R9: A start with an all-zero mask (and no R1 condition) completes in the next cycle with no memory request. Writeback, if requested, returns the base address unchanged.
- R10: `done_o` lasts one cycle after the last accepted access. A start during a transfer, or in the cycle `done_o` is high, is ignored.
- R11: While reset is active, `mem_req_o`, `rf_we_o`, `done_o`, `undef_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (accepted only when idle) |
| base_addr_i | input | 32 | Starting address |
| base_reg_i | input | 4 | Base register number, returned with writeback |
| reg_list_i | input | 16 | Register mask, bit i selects register i |
| pre_i | input | 1 | 1: step before each access, 0: after |
| up_i | input | 1 | 1: ascending order and addresses, 0: descending |
| load_i | input | 1 | 1: memory to registers, 0: registers to memory |
| wb_i | input | 1 | Request base writeback |
| priv_i | input | 1 | Privileged-mode flag (refused as undefined) |
| rf_idx_o | output | 4 | Register currently addressed |
| rf_rdata_i | input | 32 | Register-file read data for `rf_idx_o` |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the current request |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Start was refused, with `done_o` |
| wb_valid_o | output | 1 | Writeback requested, with `done_o` |
| wb_idx_o | output | 4 | Base register number for writeback |
| wb_addr_o | output | 32 | Final address for writeback |

## Verification
The hardest situations to reach from the ports are a start that lands while a transfer is still waiting on memory, and a start that lands exactly in the completion cycle. Both must be dropped with no trace. The bench gets there in two ways. It pulses start at chosen cycle offsets inside a running transfer. It also waits for the model's completion flag and pulses start in that very cycle. A pseudo-random ready pattern stretches accesses over several cycles, so the hold-stable rule is checked while the address and index are frozen. Mask corners cover a single top register, a fifteen-register mask and a descending walk that wraps below address zero.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    localparam int REG_CNT = 16;
    localparam int IDX_W   = $clog2(REG_CNT);
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int STEP_B  = DATA_W / 8;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [REG_CNT-1:0]  pend;
        logic [ADDR_W-1:0]   cur;
        logic [IDX_W-1:0]    breg;
        logic                up;
        logic                pre;
        logic                load;
        logic                wb;
        logic                done;
        logic                undef;
        logic                wbv;
        logic [ADDR_W-1:0]   fin;
    } seq_ctx_t;
endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic          low_first,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    always_comb begin
        idx = '0;
        if (low_first) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (mask[i]) idx = IW'(i);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (mask[i]) idx = IW'(i);
            end
        end
        oh = mask & (N'(1) << idx);
    end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_comb begin
        nxt_addr = up ? (cur + STEP_V) : (cur - STEP_V);
        acc_addr = pre ? nxt_addr : cur;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [IDX_W-1:0]   base_reg_i,
    input  logic [REG_CNT-1:0] reg_list_i,
    input  logic               pre_i,
    input  logic               up_i,
    input  logic               load_i,
    input  logic               wb_i,
    input  logic               priv_i,
    output logic [IDX_W-1:0]   rf_idx_o,
    input  logic [DATA_W-1:0]  rf_rdata_i,
    output logic               rf_we_o,
    output logic [DATA_W-1:0]  rf_wdata_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic               mem_ready_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               done_o,
    output logic               undef_o,
    output logic               wb_valid_o,
    output logic [IDX_W-1:0]   wb_idx_o,
    output logic [ADDR_W-1:0]  wb_addr_o
);
    localparam int TOP_BIT = REG_CNT - 1;

    seq_ctx_t q, d;

    logic [IDX_W-1:0]   sel_idx;
    logic [REG_CNT-1:0] sel_oh;
    logic [ADDR_W-1:0]  acc_addr;
    logic [ADDR_W-1:0]  nxt_addr;
    logic               running;
    logic               bad_req;

    // Next register to visit: lowest pending when ascending, highest when descending.
    xfer_pick #(.N(REG_CNT), .IW(IDX_W)) u_pick (
        .mask      (q.pend),
        .low_first (q.up),
        .idx       (sel_idx),
        .oh        (sel_oh)
    );

    // Step unit: address of this access and the running address after it.
    xfer_addr #(.AW(ADDR_W), .STEP(STEP_B)) u_addr (
        .cur      (q.cur),
        .up       (q.up),
        .pre      (q.pre),
        .acc_addr (acc_addr),
        .nxt_addr (nxt_addr)
    );

    assign running = (q.st == S_RUN);
    assign bad_req = reg_list_i[TOP_BIT] | priv_i;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.undef = 1'b0;
        d.wbv   = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                // The completion cycle counts as busy: a start there is dropped.
                if (start_i && !q.done) begin
                    if (bad_req) begin
                        d.done  = 1'b1;
                        d.undef = 1'b1;
                    end else if (reg_list_i == '0) begin
                        d.done = 1'b1;
                        d.wbv  = wb_i;
                        d.fin  = base_addr_i;
                        d.breg = base_reg_i;
                    end else begin
                        d.st   = S_RUN;
                        d.pend = reg_list_i;
                        d.cur  = base_addr_i;
                        d.breg = base_reg_i;
                        d.up   = up_i;
                        d.pre  = pre_i;
                        d.load = load_i;
                        d.wb   = wb_i;
                    end
                end
            end
            S_RUN: begin
                if (mem_ready_i) begin
                    d.pend = q.pend & ~sel_oh;
                    d.cur  = nxt_addr;
                    if ((q.pend & ~sel_oh) == '0) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.wbv  = q.wb;
                        d.fin  = nxt_addr;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rf_idx_o    = sel_idx;
    assign rf_we_o     = running & q.load & mem_ready_i;
    assign rf_wdata_o  = mem_rdata_i;
    assign mem_req_o   = running;
    assign mem_we_o    = running & ~q.load;
    assign mem_addr_o  = acc_addr;
    assign mem_wdata_o = rf_rdata_i;
    assign done_o      = q.done;
    assign undef_o     = q.undef;
    assign wb_valid_o  = q.wbv;
    assign wb_idx_o    = q.breg;
    assign wb_addr_o   = q.fin;
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk
    import blk_xfer_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [REG_CNT-1:0] reg_list_i,
    input logic               priv_i,
    input logic               mem_req_o,
    input logic               mem_ready_i,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               mem_we_o,
    input logic [IDX_W-1:0]   rf_idx_o,
    input logic               rf_we_o,
    input logic               done_o,
    input logic               undef_o,
    input logic               wb_valid_o
);
    // R1
    refuse_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && !done_o && (reg_list_i[REG_CNT-1] || priv_i)
        |=> done_o && undef_o && !mem_req_o && !wb_valid_o);

    // R1
    undef_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> done_o && !wb_valid_o && !mem_req_o);

    // R5
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> mem_req_o && mem_ready_i && !mem_we_o);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i
        |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(rf_idx_o));

    // R9
    empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && !done_o && (reg_list_i == '0) && !priv_i
        |=> done_o && !undef_o && !mem_req_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind blk_xfer_seq blk_xfer_chk u_chk (.*);

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [3:0]  base_reg_i = '0;
    logic [15:0] reg_list_i = '0;
    logic        pre_i = 1'b0, up_i = 1'b0, load_i = 1'b0, wb_i = 1'b0, priv_i = 1'b0;
    logic [3:0]  rf_idx_o;
    logic [31:0] rf_rdata_i;
    logic        rf_we_o;
    logic [31:0] rf_wdata_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_rdata_i;
    logic        done_o, undef_o, wb_valid_o;
    logic [3:0]  wb_idx_o;
    logic [31:0] wb_addr_o;

    always #2.5 clk = ~clk;

    logic [31:0] rf_file [16];
    initial for (int i = 0; i < 16; i++) rf_file[i] = 32'hC0DE_0000 + 32'h111 * i;
    assign rf_rdata_i  = rf_file[rf_idx_o];
    assign mem_rdata_i = mem_addr_o ^ 32'h5A5A_0F0F;

    blk_xfer_seq dut (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_tag = "R10";

    // Behavioural reference model
    bit          m_busy = 0, m_done = 0, m_undef = 0, m_wbv = 0;
    bit          m_up = 0, m_pre = 0, m_load = 0, m_wb = 0;
    logic [3:0]  m_breg = '0;
    logic [31:0] m_cur = '0, m_fin = '0;
    int          m_q[$];

    always @(posedge clk) begin
        bit pd;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_undef = 0; m_wbv = 0;
            m_q.delete();
        end else begin
            pd = m_done;
            m_done = 0; m_undef = 0; m_wbv = 0;
            if (!m_busy && !pd && start_i) begin
                if (reg_list_i[15] || priv_i) begin
                    m_done = 1; m_undef = 1;
                end else begin
                    m_q.delete();
                    if (up_i) begin
                        for (int i = 0; i < 16; i++) if (reg_list_i[i]) m_q.push_back(i);
                    end else begin
                        for (int i = 15; i >= 0; i--) if (reg_list_i[i]) m_q.push_back(i);
                    end
                    m_up = up_i; m_pre = pre_i; m_load = load_i; m_wb = wb_i;
                    m_breg = base_reg_i; m_cur = base_addr_i;
                    if (m_q.size() == 0) begin
                        m_done = 1; m_wbv = wb_i; m_fin = base_addr_i;
                    end else begin
                        m_busy = 1;
                    end
                end
            end else if (m_busy && mem_ready_i) begin
                m_cur = m_up ? m_cur + 32'd4 : m_cur - 32'd4;
                void'(m_q.pop_front());
                if (m_q.size() == 0) begin
                    m_busy = 0; m_done = 1; m_wbv = m_wb; m_fin = m_cur;
                end
            end
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    logic [15:0] lfsr = 16'hACE1;
    bit          hold_low = 0;

    always @(negedge clk) begin
        logic [31:0] ea;
        cyc++;
        if (!rst_n) begin
            // R11
            cmp("R11 mem_req", 32'(mem_req_o), 0);
            cmp("R11 rf_we", 32'(rf_we_o), 0);
            cmp("R11 done", 32'(done_o), 0);
            cmp("R11 undef", 32'(undef_o), 0);
            cmp("R11 wb_valid", 32'(wb_valid_o), 0);
        end else begin
            cmp($sformatf("R8 R10 %s mem_req", cur_tag), 32'(mem_req_o), 32'(m_busy));
            if (m_busy) begin
                ea = m_pre ? (m_up ? m_cur + 32'd4 : m_cur - 32'd4) : m_cur;
                cmp($sformatf("R4 %s addr", m_up ? "R2" : "R3"), mem_addr_o, ea);
                cmp($sformatf("%s rf_idx", m_up ? "R2" : "R3"), 32'(rf_idx_o), 32'(m_q[0]));
                cmp("R6 mem_we", 32'(mem_we_o), 32'(!m_load));
                if (!m_load) cmp("R6 wdata", mem_wdata_o, rf_file[m_q[0]]);
                cmp("R5 rf_we", 32'(rf_we_o), 32'(m_load && mem_ready_i));
                if (m_load && mem_ready_i) cmp("R5 rf_wdata", rf_wdata_o, mem_rdata_i);
            end else begin
                cmp("R5 rf_we idle", 32'(rf_we_o), 0);
            end
            cmp($sformatf("R10 %s done", cur_tag), 32'(done_o), 32'(m_done));
            cmp("R1 undef", 32'(undef_o), 32'(m_undef));
            cmp($sformatf("R7 %s wb_valid", cur_tag), 32'(wb_valid_o), 32'(m_wbv));
            if (m_wbv) begin
                cmp($sformatf("R7 %s wb_addr", cur_tag), wb_addr_o, m_fin);
                cmp("R7 wb_idx", 32'(wb_idx_o), 32'(m_breg));
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready_i = hold_low ? 1'b0 : (lfsr[0] | lfsr[3]);
    end

    task automatic kick(logic [31:0] base, logic [3:0] br, logic [15:0] lst,
                        bit pre, bit up, bit ld, bit wb, bit pv);
        @(negedge clk);
        start_i = 1; base_addr_i = base; base_reg_i = br; reg_list_i = lst;
        pre_i = pre; up_i = up; load_i = ld; wb_i = wb; priv_i = pv;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic settle();
        while (m_busy || m_done) @(negedge clk);
    endtask

    task automatic run(string tag, logic [31:0] base, logic [3:0] br, logic [15:0] lst,
                       bit pre, bit up, bit ld, bit wb, bit pv);
        cur_tag = tag;
        kick(base, br, lst, pre, up, ld, wb, pv);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        run("R2",  32'h0000_1000, 4'd1,  16'h00F1, 0, 1, 1, 1, 0);
        run("R3",  32'h0000_2000, 4'd13, 16'h0E06, 1, 0, 0, 1, 0);
        run("R4",  32'h0000_3000, 4'd2,  16'h0421, 1, 1, 0, 0, 0);
        run("R4",  32'h0000_4000, 4'd3,  16'h1111, 0, 0, 1, 1, 0);
        run("R9",  32'h0000_5000, 4'd4,  16'h0000, 0, 1, 1, 1, 0);
        run("R9",  32'h0000_5100, 4'd4,  16'h0000, 1, 0, 0, 0, 0);
        run("R1",  32'h0000_6000, 4'd5,  16'h8001, 0, 1, 1, 1, 0);
        run("R1",  32'h0000_6100, 4'd5,  16'h0003, 0, 1, 0, 1, 1);
        run("R3",  32'h0000_7000, 4'd6,  16'h4000, 1, 0, 1, 1, 0);
        run("R2",  32'h0000_8000, 4'd7,  16'h7FFF, 0, 1, 0, 1, 0);
        run("R3",  32'h0000_0004, 4'd8,  16'h0303, 0, 0, 1, 1, 0);
        // R8: ready held low for a long stretch mid-transfer
        cur_tag = "R8";
        kick(32'h0000_9000, 4'd9, 16'h0030, 1, 1, 0, 1, 0);
        hold_low = 1; repeat (6) @(negedge clk); hold_low = 0;
        settle();
        // R10: start pulsed while running must be dropped
        cur_tag = "R10";
        kick(32'h0000_A000, 4'd10, 16'h00F0, 0, 1, 1, 1, 0);
        hold_low = 1;
        kick(32'h0000_B000, 4'd11, 16'h8000, 0, 1, 1, 1, 0);
        kick(32'h0000_C000, 4'd12, 16'h0001, 0, 0, 0, 1, 0);
        hold_low = 0;
        settle();
        // R10: start in the completion cycle must be dropped
        kick(32'h0000_D000, 4'd14, 16'h0002, 0, 1, 0, 1, 0);
        while (!m_done) @(negedge clk);
        start_i = 1; base_addr_i = 32'h0000_E000; reg_list_i = 16'h0000; wb_i = 1;
        @(negedge clk);
        start_i = 0;
        settle();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule